// File: doc/BRIEF.md
# Write-Back Data Cache Controller

This block is a direct-mapped, write-back data cache with 32-byte lines. Each line has a valid bit and a dirty bit. The core presents one request at a time on a valid/ready port. A request is one of:

- a load or a store of one 32-bit word;
- a maintenance command: invalidate, purge, write-back or allocate;
- a prefetch hint.

A prefetch request also carries two fault flags from the address translator: a translation miss and a protection fault. Below the cache, a line-wide memory port carries whole-line fills and whole-line write-backs. The port uses a request/acknowledge handshake, with one transfer in flight at a time. The cache does no snooping. Software keeps the cache coherent with memory using the maintenance commands.

A configuration input picks how the line index is formed. In linear mode the index comes from address bits [13:5]. In split mode, address bit 25 replaces bit 13 as the top index bit, which makes two halves of the cache that bit 25 selects. The tag always stores address bits [31:5]. Aliasing across modes therefore cannot make a wrong hit.

The controller is one state machine with five named states:

- **IDLE**: waits for a request and captures it (*accept*: IDLE→LOOKUP).
- **LOOKUP**: checks the addressed line. From here:
  - *finish*: LOOKUP→RESP;
  - *evict*: LOOKUP→EVICT, when a dirty line has to leave the cache;
  - *refill*: LOOKUP→FILL, when a clean or empty line has to be loaded.
- **EVICT**: writes a line to memory. On acknowledge it either:
  - *relookup*: EVICT→LOOKUP, after a victim eviction; or
  - *finish*: EVICT→RESP, after a purge or a write-back command.
- **FILL**: reads a line from memory. On acknowledge it installs the line (*relookup*: FILL→LOOKUP).
- **RESP**: pulses done for one cycle (*release*: RESP→IDLE).

Top module: `dcache_ctrl`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, `rsp_done` is 0 and `mem_req` is 0.
- R2: With `cfg_split`=0 the index is address bits [13:5]. With `cfg_split`=1 the index is {bit 25, bits [12:5]}. The mode is sampled when a request is accepted. The tag is address bits [31:5].
- R3: A load (op code 0) that hits returns the word selected by address bits [4:2] and makes no memory transfer. A load that misses reads the line from memory first and then returns the word.
- R4: A store (op code 1) that hits replaces the selected word, sets the dirty bit and makes no memory transfer. A store that misses fills the line first and then merges the word.
- R5: Before a different line is installed at an index, a valid dirty victim at that index is written to memory. A clean victim is dropped without any transfer.
- R6: Invalidate (op code 2) clears the valid bit of a matching line and never writes to memory. Any store data in that line is lost.
- R7: Purge (op code 3) on a dirty hit writes the line to memory and then invalidates it. On a clean hit it invalidates the line with no transfer. On a miss it does nothing.
- R8: Write-back (op code 4) on a dirty hit writes the line to memory and clears its dirty bit; the line stays valid. In every other case it makes no transfer.
- R9: Allocate (op code 5) never reads memory. On a miss it claims the line (after evicting a dirty victim), with all words zero except the merged store word, and marks it valid and dirty. On a hit it merges the word like a store.
- R10: Prefetch (op code 6) completes with no memory transfer and no change to the cache in these cases: it hits, or `req_tlb_miss` is set, or `req_prot_fault` is set. Otherwise it fills the line, evicting a dirty victim first, and returns no data.
- R11: `mem_req` is never high while `req_ready` is high. Once raised, `mem_req` keeps `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`, and drops in the cycle after it.
- R12: Every accepted request produces exactly one single-cycle `rsp_done` pulse. For a load, `rsp_rdata` is valid while `rsp_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | Index mode: 0 linear, 1 split on address bit 25 |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_op | input | 3 | Operation code (0..6, see requirements) |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store / allocate data word |
| req_tlb_miss | input | 1 | Translation miss flag (acts on prefetch) |
| req_prot_fault | input | 1 | Protection fault flag (acts on prefetch) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load result |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a line write, 0 for a line read |
| mem_addr | output | 27 | Line address (byte address bits [31:5]) |
| mem_wdata | output | 256 | Line data to write |
| mem_ack | input | 1 | Memory transfer complete |
| mem_rdata | input | 256 | Line data read, valid with `mem_ack` |

## Verification
The bench counts line reads and line writes on the memory port around every operation. That catches designs that leak traffic:

- a write-back on a clean line;
- a prefetch that ignores its fault flags;
- an allocate that fetches.

It invalidates a dirty line and reloads it. This exposes a design that writes the line back on invalidate, or keeps it valid. It repeats the write-back command to show the dirty bit was cleared. It sweeps sixteen indexes through fill, hit, store and conflict passes, so a wrong index bit or a dropped victim eviction shows up as wrong data or wrong counts. Finally, it runs address pairs that differ in bit 13 or bit 25 under both index modes. A design with the wrong index mapping then produces an extra refill or a missing one.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_INVAL = 3'd2,
        OP_PURGE = 3'd3,
        OP_WBACK = 3'd4,
        OP_ALLOC = 3'd5,
        OP_PREF  = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_RESP
    } state_e;

endpackage

// File: rtl/dc_index.sv
module dc_index #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 5,
    parameter int INDEX_W = 9,
    parameter int HI_BIT  = 25
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               split,
    output logic [INDEX_W-1:0] idx
);
    logic unused_addr;
    assign unused_addr = ^addr;

    // Split mode trades the top linear index bit for the high address bit.
    always_comb begin
        if (split) idx = {addr[HI_BIT], addr[OFF_W +: INDEX_W-1]};
        else       idx = addr[OFF_W +: INDEX_W];
    end
endmodule

// File: rtl/dc_store.sv
module dc_store #(
    parameter int INDEX_W = 9,
    parameter int TAG_W   = 27,
    parameter int LINE_W  = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] idx,
    input  logic               wr_line,
    input  logic [LINE_W-1:0]  line_d,
    input  logic               wr_tag,
    input  logic [TAG_W-1:0]   tag_d,
    input  logic               wr_meta,
    input  logic               valid_d,
    input  logic               dirty_d,
    output logic [LINE_W-1:0]  rd_line,
    output logic [TAG_W-1:0]   rd_tag,
    output logic               rd_valid,
    output logic               rd_dirty
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINE_W-1:0] data_mem [LINES];
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [LINES-1:0]  valid_bits;
    logic [LINES-1:0]  dirty_bits;

    always_ff @(posedge clk) begin
        if (wr_line) data_mem[idx] <= line_d;
        if (wr_tag)  tag_mem[idx]  <= tag_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_bits <= '0;
            dirty_bits <= '0;
        end else if (wr_meta) begin
            valid_bits[idx] <= valid_d;
            dirty_bits[idx] <= dirty_d;
        end
    end

    assign rd_line  = data_mem[idx];
    assign rd_tag   = tag_mem[idx];
    assign rd_valid = valid_bits[idx];
    assign rd_dirty = dirty_bits[idx];
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int INDEX_W    = 9,
    parameter int HI_BIT     = 25,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_split,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              req_tlb_miss,
    input  logic              req_prot_fault,
    output logic              rsp_done,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [TAG_W-1:0]  mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    import dcache_pkg::*;

    localparam int BOFF_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFF_W - BOFF_W;

    state_e            state_q, state_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q, rdata_q;
    logic              skip_q, split_q;

    logic [INDEX_W-1:0] idx;
    logic [TAG_W-1:0]   tag_q, rd_tag;
    logic [WSEL_W-1:0]  wsel;
    logic [LINE_W-1:0]  rd_line, line_d;
    logic               rd_valid, rd_dirty, hit, victim_dirty;
    logic               wr_line, wr_tag, wr_meta, valid_d, dirty_d, take_word;

    function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                   input logic [WSEL_W-1:0] s,
                                                   input logic [WORD_W-1:0] w);
        logic [LINE_W-1:0] r;
        r = l;
        r[s*WORD_W +: WORD_W] = w;
        return r;
    endfunction

    dc_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .INDEX_W(INDEX_W), .HI_BIT(HI_BIT)) u_index (
        .addr(addr_q), .split(split_q), .idx(idx)
    );

    dc_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .wr_line(wr_line), .line_d(line_d), .wr_tag(wr_tag), .tag_d(tag_q),
        .wr_meta(wr_meta), .valid_d(valid_d), .dirty_d(dirty_d),
        .rd_line(rd_line), .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty)
    );

    assign tag_q        = addr_q[ADDR_W-1:OFF_W];
    assign wsel         = addr_q[BOFF_W +: WSEL_W];
    assign hit          = rd_valid && (rd_tag == tag_q);
    assign victim_dirty = rd_valid && rd_dirty;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and load result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            skip_q  <= 1'b0;
            split_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_q    <= op_e'(req_op);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                skip_q  <= req_tlb_miss | req_prot_fault;
                split_q <= cfg_split;
            end
            if (take_word) rdata_q <= rd_line[wsel*WORD_W +: WORD_W];
        end
    end

    // Next state, array commands and port outputs
    always_comb begin
        state_d   = state_q;
        wr_line   = 1'b0;
        wr_tag    = 1'b0;
        wr_meta   = 1'b0;
        valid_d   = 1'b0;
        dirty_d   = 1'b0;
        line_d    = rd_line;
        take_word = 1'b0;
        req_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_RESP);
        rsp_rdata = rdata_q;
        mem_req   = (state_q == ST_EVICT) || (state_q == ST_FILL);
        mem_we    = (state_q == ST_EVICT);
        mem_addr  = (state_q == ST_EVICT) ? rd_tag : tag_q;
        mem_wdata = rd_line;

        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOOKUP;

            ST_LOOKUP: begin
                state_d = ST_RESP;
                if (!(op_q == OP_PREF && skip_q)) begin
                    unique case (op_q)
                        OP_LOAD, OP_PREF: begin
                            if (hit) take_word = (op_q == OP_LOAD);
                            else     state_d = victim_dirty ? ST_EVICT : ST_FILL;
                        end
                        OP_STORE: begin
                            if (hit) begin
                                wr_line = 1'b1;
                                line_d  = put_word(rd_line, wsel, wdata_q);
                                wr_meta = 1'b1;
                                valid_d = 1'b1;
                                dirty_d = 1'b1;
                            end else begin
                                state_d = victim_dirty ? ST_EVICT : ST_FILL;
                            end
                        end
                        OP_INVAL: begin
                            wr_meta = hit;
                        end
                        OP_PURGE: begin
                            if (hit && rd_dirty) state_d = ST_EVICT;
                            else                 wr_meta = hit;
                        end
                        OP_WBACK: begin
                            if (hit && rd_dirty) state_d = ST_EVICT;
                        end
                        OP_ALLOC: begin
                            if (!hit && victim_dirty) begin
                                state_d = ST_EVICT;
                            end else begin
                                wr_line = 1'b1;
                                line_d  = put_word(hit ? rd_line : '0, wsel, wdata_q);
                                wr_tag  = !hit;
                                wr_meta = 1'b1;
                                valid_d = 1'b1;
                                dirty_d = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end

            ST_EVICT: if (mem_ack) begin
                wr_meta = 1'b1;
                if (op_q == OP_WBACK) begin
                    valid_d = 1'b1;
                    state_d = ST_RESP;
                end else if (op_q == OP_PURGE) begin
                    state_d = ST_RESP;
                end else begin
                    state_d = ST_LOOKUP;
                end
            end

            ST_FILL: if (mem_ack) begin
                wr_line = 1'b1;
                line_d  = mem_rdata;
                wr_tag  = 1'b1;
                wr_meta = 1'b1;
                valid_d = 1'b1;
                state_d = ST_LOOKUP;
            end

            ST_RESP: state_d = ST_IDLE;

            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
    parameter int TAG_W  = 27,
    parameter int LINE_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [TAG_W-1:0]  mem_addr,
    input logic [LINE_W-1:0] mem_wdata,
    input logic [2:0]        op_q,
    input logic              skip_q
);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    a_r11_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r6_inval_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (op_q != 3'd2));

    a_r9_alloc_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (op_q != 3'd5));

    a_r10_pref_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && op_q == 3'd6 && skip_q) |-> !mem_req);
endmodule

bind dcache_ctrl dc_checker #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .op_q(op_q), .skip_q(skip_q)
);

// File: tb/tb_dcache_ctrl.sv
`timescale 1ns/1ps
module tb_dcache_ctrl;
    localparam int TAG_W  = 27;
    localparam int LINE_W = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_split = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = '0;
    logic [31:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_tlb_miss = 1'b0;
    logic              req_prot_fault = 1'b0;
    logic              rsp_done;
    logic [31:0]       rsp_rdata;
    logic              mem_req, mem_we;
    logic [TAG_W-1:0]  mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [LINE_W-1:0] mem_rdata = '0;

    dcache_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_tlb_miss(req_tlb_miss), .req_prot_fault(req_prot_fault),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, n_rd = 0, n_wr = 0, rd0 = 0, wr0 = 0;
    logic [31:0] got;
    logic [LINE_W-1:0] wmem [logic [TAG_W-1:0]];

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {2'b00, a[31:2]} ^ 32'h5A00_0000;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [LINE_W-1:0] l;
        if (wmem.exists(a[31:5])) begin
            l = wmem[a[31:5]];
            return l[a[4:2]*32 +: 32];
        end
        return pat(a);
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic mark();
        rd0 = n_rd;
        wr0 = n_wr;
    endtask

    task automatic traffic(input string r, input int drd, input int dwr);
        chk((n_rd - rd0) == drd, {r, " line reads"}, n_rd - rd0, drd);
        chk((n_wr - wr0) == dwr, {r, " line writes"}, n_wr - wr0, dwr);
    endtask

    // Memory responder: two-cycle latency, one-cycle ack
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                logic [TAG_W-1:0] a_s;
                logic             we_s;
                a_s  = mem_addr;
                we_s = mem_we;
                repeat (2) @(negedge clk);
                chk(mem_req && mem_addr == a_s && mem_we == we_s, "R11 request held",
                    {5'd0, mem_addr}, {5'd0, a_s});
                if (mem_we) begin
                    wmem[mem_addr] = mem_wdata;
                    n_wr++;
                end else begin
                    for (int w = 0; w < 8; w++)
                        mem_rdata[w*32 +: 32] = mem_word({mem_addr, w[2:0], 2'b00});
                    n_rd++;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    task automatic op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] d, input logic [1:0] flt);
        int n;
        n = 0;
        while (!req_ready && n < 1000) begin @(negedge clk); n++; end
        req_valid      = 1'b1;
        req_op         = o;
        req_addr       = a;
        req_wdata      = d;
        req_tlb_miss   = flt[0];
        req_prot_fault = flt[1];
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_done && n < 1000) begin @(negedge clk); n++; end
        chk(rsp_done, "R12 done pulse seen", {31'd0, rsp_done}, 32'd1);
        got = rsp_rdata;
        @(negedge clk);
        chk(!rsp_done, "R12 done lasts one cycle", {31'd0, rsp_done}, 32'd0);
    endtask

    task automatic do_reset(input logic split);
        rst_n = 1'b0;
        cfg_split = split;
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_done && !mem_req, "R1 reset outputs",
            {29'd0, req_ready, rsp_done, mem_req}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    localparam logic [31:0] A = 32'h0000_1048;
    localparam logic [31:0] B = 32'h0000_5048;
    localparam logic [31:0] C = 32'h0002_0064;
    localparam logic [31:0] D = 32'h0003_0088;
    localparam logic [31:0] P = 32'h0004_00A0;
    localparam logic [31:0] Q = 32'h0005_00C0;
    localparam logic [31:0] X = 32'h0000_0048;

    initial begin
        do_reset(1'b0);

        // Loads
        mark(); op(3'd0, A, 0, 0);
        chk(got == pat(A), "R3 load miss data", got, pat(A)); traffic("R3 load miss", 1, 0);
        mark(); op(3'd0, A, 0, 0);
        chk(got == pat(A), "R3 load hit data", got, pat(A)); traffic("R3 load hit", 0, 0);

        // Store hit
        mark(); op(3'd1, A, 32'hDEAD_0001, 0); op(3'd0, A, 0, 0);
        chk(got == 32'hDEAD_0001, "R4 store hit merge", got, 32'hDEAD_0001); traffic("R4 store hit", 0, 0);

        // Write-back command
        mark(); op(3'd4, A, 0, 0); traffic("R8 wback dirty", 0, 1);
        chk(mem_word(A) == 32'hDEAD_0001, "R8 wback data", mem_word(A), 32'hDEAD_0001);
        mark(); op(3'd0, A, 0, 0); traffic("R8 line stays valid", 0, 0);
        mark(); op(3'd4, A, 0, 0); traffic("R8 dirty cleared", 0, 0);

        // Invalidate drops dirty data
        op(3'd1, A, 32'h1111_2222, 0);
        mark(); op(3'd2, A, 0, 0); traffic("R6 inval no write", 0, 0);
        mark(); op(3'd0, A, 0, 0); traffic("R6 inval then reload", 1, 0);
        chk(got == 32'hDEAD_0001, "R6 store lost", got, 32'hDEAD_0001);

        // Purge
        op(3'd1, A, 32'h0000_3333, 0);
        mark(); op(3'd3, A, 0, 0); traffic("R7 purge dirty", 0, 1);
        mark(); op(3'd0, A, 0, 0); traffic("R7 purged line refetched", 1, 0);
        chk(got == 32'h0000_3333, "R7 purge data", got, 32'h0000_3333);
        mark(); op(3'd3, A, 0, 0); traffic("R7 purge clean", 0, 0);
        mark(); op(3'd0, A, 0, 0); traffic("R7 clean purge invalidates", 1, 0);
        mark(); op(3'd3, B, 0, 0); traffic("R7 purge miss", 0, 0);

        // Conflict eviction
        op(3'd1, A, 32'h0000_4444, 0);
        mark(); op(3'd0, B, 0, 0); traffic("R5 dirty victim", 1, 1);
        chk(got == pat(B), "R5 conflict load data", got, pat(B));
        chk(mem_word(A) == 32'h0000_4444, "R5 victim data", mem_word(A), 32'h0000_4444);
        mark(); op(3'd0, A, 0, 0); traffic("R5 clean victim dropped", 1, 0);
        chk(got == 32'h0000_4444, "R5 reload data", got, 32'h0000_4444);

        // Store miss
        mark(); op(3'd1, C, 32'h0000_0055, 0); traffic("R4 store miss fills", 1, 0);
        mark(); op(3'd0, C, 0, 0); op(3'd0, C + 4, 0, 0); traffic("R4 store miss then hits", 0, 0);
        chk(got == pat(C + 4), "R4 neighbour word kept", got, pat(C + 4));

        // Allocate
        mark(); op(3'd5, D, 32'h0000_0066, 0); traffic("R9 alloc no fetch", 0, 0);
        op(3'd0, D, 0, 0);
        chk(got == 32'h0000_0066, "R9 alloc word", got, 32'h0000_0066);
        op(3'd0, D + 4, 0, 0);
        chk(got == 32'h0, "R9 alloc other word zero", got, 32'h0);
        mark(); op(3'd5, D + 32'h4000, 32'h0000_0077, 0); traffic("R9 alloc dirty victim", 0, 1);
        chk(mem_word(D) == 32'h0000_0066, "R9 victim data", mem_word(D), 32'h0000_0066);
        mark(); op(3'd0, D + 32'h4000, 0, 0); traffic("R9 allocated line hits", 0, 0);
        chk(got == 32'h0000_0077, "R9 alloc data", got, 32'h0000_0077);

        // Prefetch
        mark(); op(3'd6, P, 0, 0); traffic("R10 pref miss fills", 1, 0);
        mark(); op(3'd0, P, 0, 0); traffic("R10 pref line hits", 0, 0);
        chk(got == pat(P), "R10 pref data", got, pat(P));
        mark(); op(3'd6, P, 0, 0); traffic("R10 pref hit no-op", 0, 0);
        mark(); op(3'd6, Q, 0, 2'b01); traffic("R10 pref tlb miss", 0, 0);
        mark(); op(3'd6, Q, 0, 2'b10); traffic("R10 pref prot fault", 0, 0);
        mark(); op(3'd0, Q, 0, 0); traffic("R10 faulted pref left no line", 1, 0);
        op(3'd1, P, 32'h0000_0088, 0);
        mark(); op(3'd6, P + 32'h4000, 0, 0); traffic("R10 pref dirty victim", 1, 1);

        // Sweep over sixteen indexes
        do_reset(1'b0);
        mark();
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a;
            a = 32'h8000 + i * 32 + (i % 8) * 4;
            op(3'd0, a, 0, 0);
            chk(got == pat(a), "R3 sweep fill data", got, pat(a));
        end
        traffic("R3 sweep fills", 16, 0);
        mark();
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a;
            a = 32'h8000 + i * 32 + (i % 8) * 4;
            op(3'd1, a, i * 32'h101 + 7, 0);
            op(3'd0, a, 0, 0);
            chk(got == i * 32'h101 + 7, "R4 sweep store data", got, i * 32'h101 + 7);
        end
        traffic("R4 sweep hits", 0, 0);
        mark();
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a;
            a = 32'h8000 + i * 32 + (i % 8) * 4;
            op(3'd0, a + 32'h4000, 0, 0);
            chk(mem_word(a) == i * 32'h101 + 7, "R5 sweep victim data", mem_word(a), i * 32'h101 + 7);
        end
        traffic("R5 sweep evictions", 16, 16);

        // Index modes
        do_reset(1'b0);
        mark();
        op(3'd0, X, 0, 0); op(3'd0, X | 32'h0200_0000, 0, 0); op(3'd0, X, 0, 0);
        traffic("R2 linear: bit 25 aliases", 3, 0);
        mark();
        op(3'd0, X | 32'h2000, 0, 0); op(3'd0, X, 0, 0);
        traffic("R2 linear: bit 13 separates", 1, 0);
        chk(got == pat(X), "R2 linear data", got, pat(X));

        do_reset(1'b1);
        mark();
        op(3'd0, X, 0, 0); op(3'd0, X | 32'h0200_0000, 0, 0); op(3'd0, X, 0, 0);
        traffic("R2 split: bit 25 separates", 2, 0);
        chk(got == pat(X), "R2 split data", got, pat(X));
        mark();
        op(3'd0, X | 32'h2000, 0, 0); op(3'd0, X, 0, 0);
        traffic("R2 split: bit 13 aliases", 2, 0);
        chk(got == pat(X), "R2 split reload data", got, pat(X));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule